// File: doc/BRIEF.md
# Display Serializer Power Sequencer

This block drives the control registers of a parallel-to-serial display transmitter through its power-up and power-down orders. An enable request captures the configuration straps, the bus-format code, the mirror flag, the source index and the requested pixel clock. It then issues one register write at a time on a simple strobe/address/data port. The routing registers come first, then the PLL range register, then the mode value, then channel standby. After that the main-control bits are raised one after another. Generation and PLL straps decide which of those bit steps are skipped.

With the simple PLL, a cycle-counted start-up wait of at least 100 µs comes before the final output-release write. A disable request undoes the main-control bits in the reverse order, one write per bit. It then clears the main, standby and (simple PLL only) PLL registers in full. A clamped copy of the requested pixel clock is also presented for the clock generator.

Top module: `dser_pwrseq`

## Requirements
- R1: After reset no write strobe is issued, and `busy` and `ready` are both low until an enable request arrives.
- R2: Enable order is: control routing (addr 2), lane routing (addr 3), PLL range (addr 4, simple PLL only), mode (addr 0), standby 0x1F (addr 1). The remaining steps are all main writes (addr 0), each adding bits to the previous value: bias 0x10 plus transmitter-enable 0x02 (older generation only); PLL-on 0x08 (simple PLL only); power-down-normal 0x04 (when supported); transmitter-enable 0x02 (when supported); release 0x01. `ready` rises after the release write.
- R3: The mode value places a 3-bit code at bits 10:8 and the source-select at bit 5, which is set only when `src_idx` is 2. Format codes map as follows: 0 (18-bit) and 1 (24-bit, first order) give 0; 2 (24-bit, second order) gives 4; code 3 (unsupported) gives 0. For codes 0 to 2 the mirror flag ORs in 1; for code 3 it is ignored.
- R4: The routing word is 0x0039: 2-bit fields with ctrl0=hsync(1), ctrl1=vsync(2), ctrl2=display-enable(3), ctrl3=zero(0). The lane word holds 2-bit source fields per lane: 0x00E4 for identity, 0x006C when the lane-swap strap exchanges lanes 1 and 3.
- R5: The PLL word has the range code in bits 1:0 and two clock bits at bits 2 and 3. It is taken from the clamped clock. On the older generation the codes 0/1/2/3 are chosen by below 39000, 61000 and 121000 kHz, and codes 0 to 2 also set bits 2 and 3. On the newer generation the thresholds are 42000, 85000 and 128000 kHz, and the clock bits stay clear.
- R6: `clk_khz` is `pix_khz` clamped to 5000..148500 with the extended PLL and to 31000..148500 otherwise.
- R7: When both the power-down and transmitter-enable straps are set, the transmitter-enable bit is not written alone; it first appears in the release write.
- R8: With the simple PLL, the release write follows the previous write by at least 100 µs and at most 150 µs. With the extended PLL there is no wait.
- R9: Disable writes are main writes, each removing bits from the previous value: clear release; clear transmitter-enable (if supported); clear power-down-normal (if supported); clear PLL-on (simple PLL only). These are followed by main=0, standby=0, and PLL=0 (simple PLL only).
- R10: `busy` is high during a sequence and `ready` only in the on state, never both. An enable request while not off and a disable request while not on are ignored.
- R11: Each write lasts one cycle, and two writes are separated by at least one idle cycle.
- R12: The disable order follows the straps captured at enable, not their current values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Power-up request pulse |
| dis_req | input | 1 | Power-down request pulse |
| strap_old_gen | input | 1 | Older generation: bias step and old PLL thresholds |
| strap_ext_pll | input | 1 | Extended PLL fitted (no PLL-on, PLL write or wait) |
| strap_pd_bit | input | 1 | Power-down-normal bit supported |
| strap_phy_bit | input | 1 | Transmitter-enable bit supported |
| strap_lane_swap | input | 1 | Exchange lanes 1 and 3 |
| fmt_code | input | 2 | Bus-format code |
| fmt_mirror | input | 1 | LSB-first data |
| src_idx | input | 2 | Source pipeline index |
| pix_khz | input | 18 | Requested pixel clock in kHz |
| clk_khz | output | 18 | Clamped pixel clock in kHz |
| wr_stb | output | 1 | Register write strobe |
| wr_addr | output | 3 | Register select: 0 main, 1 standby, 2 routing, 3 lanes, 4 PLL |
| wr_data | output | 16 | Register write data |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Transmitter on |

## Verification
The bench targets strap mixes that move the sequence: the power-down/transmitter-enable merge, the older-generation bias step, and the extended PLL that drops the PLL write and the wait. A design that wrote the merged bit alone, or kept the wait on the extended PLL, would show an extra write or a missing timing window. PLL thresholds are probed on both sides of their edges and with a clock above the clamp. An off-by-one compare would pick the neighbouring range code. Straps are altered between enable and disable, and requests are pulsed mid-sequence. A design reading live straps would tear down in the wrong order, and one not gating requests would restart or emit stray writes.

// File: rtl/dser_pwrseq_pkg.sv
package dser_pwrseq_pkg;

  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 3;
  localparam int FREQ_W   = 18;
  localparam int MODE_W   = 3;
  localparam int LANE_N   = 4;
  localparam int CH_SEL_W = 2;
  localparam int STBY_W   = LANE_N + 1;

  // register selects
  localparam logic [ADDR_W-1:0] A_MAIN = 3'd0;
  localparam logic [ADDR_W-1:0] A_STBY = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] A_LANE = 3'd3;
  localparam logic [ADDR_W-1:0] A_PLL  = 3'd4;

  // main-control bit positions
  localparam int B_REL   = 0;
  localparam int B_XEN   = 1;
  localparam int B_PD    = 2;
  localparam int B_PLLON = 3;
  localparam int B_BIAS  = 4;
  localparam int B_SRC   = 5;
  localparam int B_MODE  = 8;

  localparam logic [DATA_W-1:0] M_REL   = DATA_W'(1) << B_REL;
  localparam logic [DATA_W-1:0] M_XEN   = DATA_W'(1) << B_XEN;
  localparam logic [DATA_W-1:0] M_PD    = DATA_W'(1) << B_PD;
  localparam logic [DATA_W-1:0] M_PLLON = DATA_W'(1) << B_PLLON;
  localparam logic [DATA_W-1:0] M_BIAS  = DATA_W'(1) << B_BIAS;

  localparam logic [DATA_W-1:0] STBY_ALL = DATA_W'({STBY_W{1'b1}});

  // control-signal routing sources, 2 bits per output
  localparam logic [1:0] RT_ZERO = 2'd0;
  localparam logic [1:0] RT_HS   = 2'd1;
  localparam logic [1:0] RT_VS   = 2'd2;
  localparam logic [1:0] RT_DE   = 2'd3;
  localparam logic [DATA_W-1:0] CTRL_WORD =
    DATA_W'({RT_ZERO, RT_DE, RT_VS, RT_HS});

  // bus-format codes
  localparam logic [1:0] FMT_18B   = 2'd0;
  localparam logic [1:0] FMT_24B_A = 2'd1;
  localparam logic [1:0] FMT_24B_B = 2'd2;
  localparam logic [MODE_W-1:0] MODE_A = 3'd0;
  localparam logic [MODE_W-1:0] MODE_B = 3'd4;

  // pixel clock limits in kHz
  localparam int F_MAX        = 148500;
  localparam int F_MIN_EXT    = 5000;
  localparam int F_MIN_SIMPLE = 31000;
  localparam int F_OLD_T0 = 39000;
  localparam int F_OLD_T1 = 61000;
  localparam int F_OLD_T2 = 121000;
  localparam int F_NEW_T0 = 42000;
  localparam int F_NEW_T1 = 85000;
  localparam int F_NEW_T2 = 128000;

  typedef struct packed {
    logic              old_gen;
    logic              ext_pll;
    logic              pd_bit;
    logic              phy_bit;
    logic [MODE_W-1:0] mode;
    logic              src_sel;
    logic [DATA_W-1:0] lane_word;
    logic [DATA_W-1:0] pll_word;
  } cfg_t;

  typedef enum logic [4:0] {
    S_OFF, S_E_CTRL, S_E_LANE, S_E_PLL, S_E_MODE, S_E_STBY, S_E_BIAS,
    S_E_PLLON, S_E_PD, S_E_PHY, S_E_WAIT, S_E_REL, S_ON,
    S_D_REL, S_D_PHY, S_D_PD, S_D_PLLON, S_D_MAIN, S_D_STBY, S_D_PLL
  } st_t;

endpackage

// File: rtl/dser_cfg_decode.sv
module dser_cfg_decode
  import dser_pwrseq_pkg::*;
(
  input  logic              old_gen,
  input  logic              ext_pll,
  input  logic              pd_bit,
  input  logic              phy_bit,
  input  logic              lane_swap,
  input  logic [1:0]        fmt_code,
  input  logic              fmt_mirror,
  input  logic [1:0]        src_idx,
  input  logic [FREQ_W-1:0] pix_khz,
  output logic [FREQ_W-1:0] clk_khz,
  output cfg_t              cfg
);

  localparam int LANE_BITS = LANE_N * CH_SEL_W;

  logic [LANE_BITS-1:0] lanes;
  logic [FREQ_W-1:0]    f_lo;
  logic [1:0]           rng;
  logic                 ck_bits;
  logic [MODE_W-1:0]    mode;

  // clamp of requested pixel clock
  always_comb begin
    f_lo = ext_pll ? FREQ_W'(F_MIN_EXT) : FREQ_W'(F_MIN_SIMPLE);
    if (pix_khz < f_lo)                 clk_khz = f_lo;
    else if (pix_khz > FREQ_W'(F_MAX))  clk_khz = FREQ_W'(F_MAX);
    else                                clk_khz = pix_khz;
  end

  // PLL range selection
  always_comb begin
    rng     = 2'd3;
    ck_bits = 1'b0;
    if (old_gen) begin
      if      (clk_khz < FREQ_W'(F_OLD_T0)) begin rng = 2'd0; ck_bits = 1'b1; end
      else if (clk_khz < FREQ_W'(F_OLD_T1)) begin rng = 2'd1; ck_bits = 1'b1; end
      else if (clk_khz < FREQ_W'(F_OLD_T2)) begin rng = 2'd2; ck_bits = 1'b1; end
    end else begin
      if      (clk_khz < FREQ_W'(F_NEW_T0)) rng = 2'd0;
      else if (clk_khz < FREQ_W'(F_NEW_T1)) rng = 2'd1;
      else if (clk_khz < FREQ_W'(F_NEW_T2)) rng = 2'd2;
    end
  end

  // mode code from format and mirror
  always_comb begin
    unique case (fmt_code)
      FMT_18B, FMT_24B_A: mode = MODE_A | MODE_W'(fmt_mirror);
      FMT_24B_B:          mode = MODE_B | MODE_W'(fmt_mirror);
      default:            mode = MODE_A;
    endcase
  end

  // lane routing: odd lanes exchange when swapped
  for (genvar i = 0; i < LANE_N; i++) begin : g_lane
    if (i % 2 == 1) begin : g_odd
      assign lanes[i*CH_SEL_W +: CH_SEL_W] =
        lane_swap ? CH_SEL_W'(LANE_N - i) : CH_SEL_W'(i);
    end else begin : g_even
      assign lanes[i*CH_SEL_W +: CH_SEL_W] = CH_SEL_W'(i);
    end
  end

  always_comb begin
    cfg           = '0;
    cfg.old_gen   = old_gen;
    cfg.ext_pll   = ext_pll;
    cfg.pd_bit    = pd_bit;
    cfg.phy_bit   = phy_bit;
    cfg.mode      = mode;
    cfg.src_sel   = (src_idx == 2'd2);
    cfg.lane_word = DATA_W'(lanes);
    cfg.pll_word  = DATA_W'({ck_bits, ck_bits, rng});
  end

endmodule

// File: rtl/dser_wait_timer.sv
module dser_wait_timer #(
  parameter int WAIT_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int CW = $clog2(WAIT_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_en = run || (cnt_q != '0);
    cnt_n  = run ? cnt_q + CW'(1) : '0;
  end

  assign done = run && (cnt_q == CW'(WAIT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

endmodule

// File: rtl/dser_seq_fsm.sv
module dser_seq_fsm
  import dser_pwrseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_req,
  input  logic              dis_req,
  input  cfg_t              cfg,
  input  logic              tmr_done,
  output logic              accept,
  output logic              tmr_run,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              ready
);

  st_t               st_q, st_n;
  logic              gap_q, gap_n;
  logic [DATA_W-1:0] m_q, val;
  logic              act, m_en;

  function automatic st_t succ(input st_t s);
    return (s == S_D_PLL) ? S_OFF : st_t'(s + 5'd1);
  endfunction

  always_comb begin
    act     = 1'b0;
    m_en    = 1'b0;
    wr_addr = A_MAIN;
    val     = '0;
    unique case (st_q)
      S_E_CTRL:  begin act = 1'b1; wr_addr = A_CTRL; val = CTRL_WORD; end
      S_E_LANE:  begin act = 1'b1; wr_addr = A_LANE; val = cfg.lane_word; end
      S_E_PLL:   begin act = !cfg.ext_pll; wr_addr = A_PLL; val = cfg.pll_word; end
      S_E_MODE:  begin
        act = 1'b1; m_en = 1'b1;
        val[B_MODE +: MODE_W] = cfg.mode;
        val[B_SRC]            = cfg.src_sel;
      end
      S_E_STBY:  begin act = 1'b1; wr_addr = A_STBY; val = STBY_ALL; end
      S_E_BIAS:  begin act = cfg.old_gen; m_en = act; val = m_q | M_BIAS | M_XEN; end
      S_E_PLLON: begin act = !cfg.ext_pll; m_en = act; val = m_q | M_PLLON; end
      S_E_PD:    begin act = cfg.pd_bit; m_en = act; val = m_q | M_PD; end
      S_E_PHY:   begin
        act  = cfg.phy_bit && !cfg.pd_bit;
        m_en = cfg.phy_bit;
        val  = m_q | M_XEN;
      end
      S_E_REL:   begin act = 1'b1; m_en = 1'b1; val = m_q | M_REL; end
      S_D_REL:   begin act = 1'b1; m_en = 1'b1; val = m_q & ~M_REL; end
      S_D_PHY:   begin act = cfg.phy_bit; m_en = act; val = m_q & ~M_XEN; end
      S_D_PD:    begin act = cfg.pd_bit; m_en = act; val = m_q & ~M_PD; end
      S_D_PLLON: begin act = !cfg.ext_pll; m_en = act; val = m_q & ~M_PLLON; end
      S_D_MAIN:  begin act = 1'b1; m_en = 1'b1; val = '0; end
      S_D_STBY:  begin act = 1'b1; wr_addr = A_STBY; val = '0; end
      S_D_PLL:   begin act = !cfg.ext_pll; wr_addr = A_PLL; val = '0; end
      default:   begin act = 1'b0; end
    endcase
    if (gap_q) begin
      act  = 1'b0;
      m_en = 1'b0;
    end
  end

  always_comb begin
    st_n   = st_q;
    gap_n  = 1'b0;
    accept = 1'b0;
    unique case (st_q)
      S_OFF: if (en_req) begin st_n = S_E_CTRL; accept = 1'b1; end
      S_ON:  if (dis_req) st_n = S_D_REL;
      S_E_WAIT: if (cfg.ext_pll || tmr_done) st_n = succ(st_q);
      default: begin
        if (gap_q)    st_n  = succ(st_q);
        else if (act) gap_n = 1'b1;
        else          st_n  = succ(st_q);
      end
    endcase
  end

  assign tmr_run = (st_q == S_E_WAIT) && !cfg.ext_pll;
  assign wr_stb  = act;
  assign wr_data = act ? val : '0;
  assign ready   = (st_q == S_ON);
  assign busy    = (st_q != S_ON) && (st_q != S_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_OFF;
      gap_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      gap_q <= gap_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    m_q <= '0;
    else if (m_en) m_q <= val;
  end

endmodule

// File: rtl/dser_pwrseq.sv
module dser_pwrseq
  import dser_pwrseq_pkg::*;
#(
  parameter int CYC_PER_US = 50,
  parameter int WAIT_US    = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_req,
  input  logic              dis_req,
  input  logic              strap_old_gen,
  input  logic              strap_ext_pll,
  input  logic              strap_pd_bit,
  input  logic              strap_phy_bit,
  input  logic              strap_lane_swap,
  input  logic [1:0]        fmt_code,
  input  logic              fmt_mirror,
  input  logic [1:0]        src_idx,
  input  logic [FREQ_W-1:0] pix_khz,
  output logic [FREQ_W-1:0] clk_khz,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              ready
);

  localparam int WAIT_CYC = CYC_PER_US * WAIT_US;

  logic [1:0] rst_sync_q;
  logic       rst_i;
  cfg_t       cfg_live, cfg_q;
  logic       accept, tmr_run, tmr_done;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  dser_cfg_decode u_dec (
    .old_gen    (strap_old_gen),
    .ext_pll    (strap_ext_pll),
    .pd_bit     (strap_pd_bit),
    .phy_bit    (strap_phy_bit),
    .lane_swap  (strap_lane_swap),
    .fmt_code   (fmt_code),
    .fmt_mirror (fmt_mirror),
    .src_idx    (src_idx),
    .pix_khz    (pix_khz),
    .clk_khz    (clk_khz),
    .cfg        (cfg_live)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      cfg_q <= '0;
    else if (accept) cfg_q <= cfg_live;
  end

  dser_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_tmr (
    .clk   (clk),
    .rst_n (rst_i),
    .run   (tmr_run),
    .done  (tmr_done)
  );

  dser_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_i),
    .en_req   (en_req),
    .dis_req  (dis_req),
    .cfg      (cfg_q),
    .tmr_done (tmr_done),
    .accept   (accept),
    .tmr_run  (tmr_run),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .busy     (busy),
    .ready    (ready)
  );

endmodule

// File: rtl/dser_pwrseq_chk.sv
module dser_pwrseq_chk
  import dser_pwrseq_pkg::*;
#(
  parameter int CYC_PER_US = 50,
  parameter int WAIT_US    = 100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_req,
  input logic              dis_req,
  input logic              strap_ext_pll,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy,
  input logic              ready
);

  localparam int WAIT_CYC = CYC_PER_US * WAIT_US;
  localparam int CW = $clog2(WAIT_CYC + 1);

  logic          cap_simple;
  logic [CW-1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_simple <= 1'b0;
      since      <= '0;
    end else begin
      if (en_req && !busy && !ready) cap_simple <= !strap_ext_pll;
      if (wr_stb)                    since <= '0;
      else if (since != CW'(WAIT_CYC)) since <= since + CW'(1);
    end
  end

  assert_strobe_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && ready));

  assert_ready_after_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(wr_stb && wr_addr == A_MAIN && wr_data[B_REL], 2));

  assert_pll_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == A_MAIN && wr_data[B_REL] && cap_simple) |->
      (since >= CW'(WAIT_CYC)));

  assert_stby_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == A_STBY) |-> (wr_data == STBY_ALL || wr_data == '0));

  assert_en_ignored_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && en_req && !dis_req) |=> ready);

endmodule

bind dser_pwrseq dser_pwrseq_chk #(
  .CYC_PER_US (CYC_PER_US),
  .WAIT_US    (WAIT_US)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .en_req        (en_req),
  .dis_req       (dis_req),
  .strap_ext_pll (strap_ext_pll),
  .wr_stb        (wr_stb),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .busy          (busy),
  .ready         (ready)
);

// File: tb/tb_dser_pwrseq.sv
module tb_dser_pwrseq;
  import dser_pwrseq_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, en_req, dis_req;
  logic s_old, s_ext, s_pd, s_phy, s_swap, mirror;
  logic [1:0] fmt, src;
  logic [FREQ_W-1:0] pix, clk_khz;
  logic wr_stb, busy, ready;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  dser_pwrseq dut (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
    .strap_old_gen(s_old), .strap_ext_pll(s_ext), .strap_pd_bit(s_pd),
    .strap_phy_bit(s_phy), .strap_lane_swap(s_swap), .fmt_code(fmt),
    .fmt_mirror(mirror), .src_idx(src), .pix_khz(pix), .clk_khz(clk_khz),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .ready(ready)
  );

  int n_chk = 0;
  int n_bad = 0;
  longint cyc = 0;
  longint last_stb = 0;
  logic [19:0] sbq[$];
  string tagq[$];

  // captured expectation state for teardown
  logic c_ext, c_pd, c_phy;
  logic [15:0] c_m;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic push(input string rq, input logic [2:0] a, input logic [15:0] d, input bit timed);
    sbq.push_back({timed, a, d});
    tagq.push_back(rq);
  endtask

  // monitor / scoreboard compare
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R10 unexpected write", {wr_addr, wr_data}, 0);
      end else begin
        logic [19:0] it;
        string rq;
        it = sbq.pop_front();
        rq = tagq.pop_front();
        chk({wr_addr, wr_data} == it[18:0], rq, {wr_addr, wr_data}, it[18:0]);
        if (it[19]) chk((cyc - last_stb) >= 5000 && (cyc - last_stb) <= 7500,
                        "R8 wait cycles", cyc - last_stb, 5000);
      end
      last_stb = cyc;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [2:0] f_mode(input logic [1:0] f, input logic m);
    case (f)
      2'd0, 2'd1: return {2'b00, m};
      2'd2:       return {2'b10, m};
      default:    return 3'd0;
    endcase
  endfunction

  function automatic logic [15:0] f_pll(input logic old, input int khz);
    int k;
    k = (khz < 31000) ? 31000 : (khz > 148500 ? 148500 : khz);
    if (old) begin
      if (k < 39000)  return 16'h000C;
      if (k < 61000)  return 16'h000D;
      if (k < 121000) return 16'h000E;
      return 16'h0003;
    end
    if (k < 42000)  return 16'h0000;
    if (k < 85000)  return 16'h0001;
    if (k < 128000) return 16'h0002;
    return 16'h0003;
  endfunction

  task automatic set_cfg(input bit o, input bit e, input bit p, input bit h, input bit sw,
                         input logic [1:0] f, input bit mi, input logic [1:0] si, input int khz);
    s_old = o; s_ext = e; s_pd = p; s_phy = h; s_swap = sw;
    fmt = f; mirror = mi; src = si; pix = FREQ_W'(khz);
  endtask

  task automatic pulse(input bit which_en);
    @(posedge clk); #2;
    if (which_en) en_req = 1'b1; else dis_req = 1'b1;
    @(posedge clk); #2;
    en_req = 1'b0; dis_req = 1'b0;
  endtask

  task automatic do_enable(input bit poke_dis);
    logic [15:0] m;
    push("R4 routing", A_CTRL, 16'h0039, 0);
    push("R4 lanes", A_LANE, s_swap ? 16'h006C : 16'h00E4, 0);
    if (!s_ext) push("R5 pll range", A_PLL, f_pll(s_old, int'(pix)), 0);
    m = 16'(f_mode(fmt, mirror)) << 8;
    if (src == 2'd2) m |= 16'h0020;
    push("R3 mode", A_MAIN, m, 0);
    push("R2 standby", A_STBY, 16'h001F, 0);
    if (s_old) begin m |= 16'h0012; push("R2 bias", A_MAIN, m, 0); end
    if (!s_ext) begin m |= 16'h0008; push("R2 pll on", A_MAIN, m, 0); end
    if (s_pd) begin m |= 16'h0004; push("R2 pd", A_MAIN, m, 0); end
    if (s_phy) begin
      m |= 16'h0002;
      if (!s_pd) push("R2 xmit enable", A_MAIN, m, 0);
    end
    m |= 16'h0001;
    push((s_pd && s_phy) ? "R7 merged release" : "R2 release", A_MAIN, m, !s_ext);
    c_ext = s_ext; c_pd = s_pd; c_phy = s_phy; c_m = m;
    pulse(1'b1);
    if (poke_dis) begin
      repeat (40) @(posedge clk);
      pulse(1'b0);  // R10: disable while busy is ignored
    end
    for (int i = 0; i < 20000 && !ready; i++) @(negedge clk);
    @(negedge clk);
    chk(ready && !busy, "R2 ready after enable", {busy, ready}, 2'b01);
    chk(sbq.size() == 0, "R2 all enable writes seen", sbq.size(), 0);
  endtask

  task automatic do_disable(input bit poke_en);
    logic [15:0] m;
    m = c_m & ~16'h0001;
    push("R9 clear release", A_MAIN, m, 0);
    if (c_phy) begin m &= ~16'h0002; push("R9 clear xmit", A_MAIN, m, 0); end
    if (c_pd)  begin m &= ~16'h0004; push("R9 clear pd", A_MAIN, m, 0); end
    if (!c_ext) begin m &= ~16'h0008; push("R9 clear pll on", A_MAIN, m, 0); end
    push("R9 main zero", A_MAIN, 16'h0000, 0);
    push("R9 standby zero", A_STBY, 16'h0000, 0);
    if (!c_ext) push("R9 pll zero", A_PLL, 16'h0000, 0);
    pulse(1'b0);
    if (poke_en) begin
      repeat (2) @(posedge clk);
      pulse(1'b1);  // R10: enable while busy is ignored
    end
    for (int i = 0; i < 2000 && (busy || ready); i++) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(!busy && !ready, "R10 idle after disable", {busy, ready}, 0);
    chk(sbq.size() == 0, "R9 all disable writes seen", sbq.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0; en_req = 1'b0; dis_req = 1'b0;
    set_cfg(0, 0, 0, 0, 0, 2'd0, 0, 2'd0, 50000);
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (6) begin
      @(negedge clk);
      chk(!wr_stb && !busy && !ready, "R1 reset state", {wr_stb, busy, ready}, 0);
    end

    // R6 clamp
    s_ext = 0; pix = 18'd1000; #1;
    chk(clk_khz == 18'd31000, "R6 clamp low simple", clk_khz, 31000);
    s_ext = 1; #1;
    chk(clk_khz == 18'd5000, "R6 clamp low extended", clk_khz, 5000);
    pix = 18'd200000; #1;
    chk(clk_khz == 18'd148500, "R6 clamp high", clk_khz, 148500);
    s_ext = 0; pix = 18'd60000; #1;
    chk(clk_khz == 18'd60000, "R6 in range", clk_khz, 60000);

    // A: older generation, bias step, threshold just below 39000
    set_cfg(1, 0, 0, 0, 0, 2'd1, 0, 2'd2, 38999);
    do_enable(1'b1);
    pulse(1'b1);  // R10: enable while on is ignored
    repeat (30) @(negedge clk);
    chk(ready && !busy, "R10 enable ignored when on", {busy, ready}, 2'b01);
    do_disable(1'b1);

    // B: pd+phy merge (R7), lane swap, second format with mirror
    set_cfg(0, 0, 1, 1, 1, 2'd2, 1, 2'd1, 42000);
    do_enable(1'b0);
    set_cfg(1, 1, 0, 0, 0, 2'd0, 0, 2'd2, 90000);  // R12: straps change while on
    do_disable(1'b0);

    // C: extended PLL, phy alone, unsupported format ignores mirror
    set_cfg(0, 1, 0, 1, 0, 2'd3, 1, 2'd3, 20000);
    do_enable(1'b0);
    do_disable(1'b0);

    // D: older generation above clamp, pd only, 18-bit mirrored
    set_cfg(1, 0, 1, 0, 0, 2'd0, 1, 2'd0, 200000);
    do_enable(1'b0);
    do_disable(1'b0);

    // E: newer generation just below top threshold
    set_cfg(0, 0, 0, 1, 0, 2'd2, 0, 2'd2, 127999);
    do_enable(1'b0);
    do_disable(1'b0);

    // F: older generation on the 61000 edge
    set_cfg(1, 0, 0, 1, 1, 2'd1, 1, 2'd1, 61000);
    do_enable(1'b0);
    do_disable(1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule